// File: doc/BRIEF.md
# Ring Receive DMA Writer

This block takes received frames from a byte-wide AXI4-Stream input and places each one in memory. For each new frame it reads the buffer base address of the current ring slot from a descriptor lookup port. It writes the frame bytes one per cycle to consecutive addresses from that base. When the last byte arrives it writes a status word back to the slot. That word holds the stored length, frame-boundary marks and an overflow flag. In the same cycle the block advances a 16-bit producer index, and the slot pointer moves on by one.

Software consumes frames and advances a 16-bit consumer index, which is an input to the block. The difference between the producer and consumer indices is the ring occupancy. A frame that starts while the ring is full is swallowed and counted. A hysteretic flow-control output tells the link partner to pause when the free slots run low, and releases once enough slots are free again. An alignment option leaves a two-byte gap at the start of every buffer, so the network header that follows a 14-byte link header lands on a word boundary. The gap counts in the reported length.

Top module: `rx_ring_dma_writer`

## Requirements
- R1: After reset the following are all zero: the producer index, the slot pointer, the flow-control output, the drop count, the byte write strobe and the write-back strobe.
- R2: `s_axis_tready` is always high, so every beat with `s_axis_tvalid` high is consumed in its cycle.
- R3: With alignment off, the bytes of an accepted frame go to consecutive addresses starting at the `desc_buf_addr` value seen on the frame's first beat. Each byte appears on the write port one cycle after its beat.
- R4: With `align_en` high on a frame's first beat, the first byte goes to base+2, and the reported length is the stored byte count plus 2.
- R5: One cycle after the last beat of a stored frame, `wb_we` pulses for the slot that received it. The word carries the length in bits 27:16, end-of-frame in bit 14, start-of-frame in bit 13 and overflow in bit 0. `prod_idx` rises by exactly one in that same cycle.
- R6: Only 2048 bytes fit in a buffer, counting the pad. Further bytes are not written, the reported length is 2048, and bit 0 of the status word is 1.
- R7: The slot pointer counts 0 to 255 and then wraps back to 0, so the 257th stored frame is written back to slot 0.
- R8: If the occupancy ((`prod_idx` − `cons_idx`) mod 65536) is 256 or more on a frame's first beat, the whole frame is consumed without any byte write or write-back. `prod_idx` is unchanged and `drop_count` rises by one.
- R9: `xoff` rises one cycle after the free slot count (256 − occupancy) is 5 or less. It stays low while 6 or more slots are free.
- R10: Once `xoff` is high, it stays high until the free slot count is 16 or more, and it falls one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| align_en | input | 1 | Two-byte start pad enable, sampled on each first beat |
| cons_idx | input | 16 | Consumer index written by software |
| s_axis_tdata | input | 8 | Frame byte |
| s_axis_tvalid | input | 1 | Beat valid |
| s_axis_tready | output | 1 | Always ready |
| s_axis_tlast | input | 1 | Last byte of frame |
| desc_slot | output | 8 | Slot whose descriptor is looked up |
| desc_buf_addr | input | 32 | Buffer base address of `desc_slot` |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| wb_we | output | 1 | Descriptor status write strobe |
| wb_slot | output | 8 | Slot of the status write |
| wb_word | output | 32 | Status word |
| prod_idx | output | 16 | Producer index |
| xoff | output | 1 | Pause request to the link partner |
| drop_count | output | 16 | Frames discarded because the ring was full |

## Verification
Some properties are checked by assertions on every cycle:
- no byte write ever lands outside the 2048-byte buffer window;
- a status word never reports more than 2048 bytes;
- the producer index only ever steps by one, and only together with a write-back;
- the slot pointer stays in step with the producer index;
- a frame that starts on a full ring produces no write;
- the pause output changes only when the free count is across the matching threshold.

Other behaviour needs the bench's scenarios. These include the actual addresses and data written, the effect of the alignment pad on the reported length, truncation at the buffer size, slot wrap after 256 frames, drop counting, and both threshold edges of the hysteresis, one slot either side of each.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    // Status word layout written back into each ring slot.
    localparam int LEN_LSB  = 16;
    localparam int LEN_BITS = 12;
    localparam int EOF_BIT  = 14;
    localparam int SOF_BIT  = 13;
    localparam int OVF_BIT  = 0;

    function automatic logic [31:0] make_status(input logic [LEN_BITS-1:0] len,
                                                input logic ovf);
        logic [31:0] w;
        w = '0;
        w[LEN_LSB +: LEN_BITS] = len;
        w[EOF_BIT] = 1'b1;
        w[SOF_BIT] = 1'b1;
        w[OVF_BIT] = ovf;
        return w;
    endfunction

endpackage

// File: rtl/rxring_occupancy.sv
module rxring_occupancy #(
    parameter int SLOTS   = 256,
    parameter int IDX_W   = 16,
    parameter int XOFF_AT = 5,
    parameter int XON_AT  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] prod,
    input  logic [IDX_W-1:0] cons,
    output logic             full,
    output logic             xoff
);

    typedef struct packed {
        logic xoff;
    } occ_state_t;

    occ_state_t st_q, st_d;
    logic [IDX_W-1:0] used;
    logic [IDX_W-1:0] free_slots;

    always_comb begin
        used       = prod - cons;
        full       = (used >= IDX_W'(SLOTS));
        free_slots = full ? '0 : (IDX_W'(SLOTS) - used);
        st_d       = st_q;
        if (st_q.xoff) begin
            st_d.xoff = !(free_slots >= IDX_W'(XON_AT));
        end else begin
            st_d.xoff = (free_slots <= IDX_W'(XOFF_AT));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign xoff = st_q.xoff;

    // R9: pause only rises after the free count reached the low mark
    assert_xoff_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.xoff) |-> $past(free_slots <= IDX_W'(XOFF_AT)));

    // R10: pause only falls after the free count reached the high mark
    assert_xoff_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.xoff) |-> $past(free_slots >= IDX_W'(XON_AT)));

endmodule

// File: rtl/rxring_frame_writer.sv
module rxring_frame_writer
    import rxring_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int SLOT_W    = 8,
    parameter int IDX_W     = 16,
    parameter int ADDR_W    = 32,
    parameter int DROP_W    = 16,
    parameter int PAD_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              align_en,
    input  logic              full,
    input  logic [7:0]        s_data,
    input  logic              s_valid,
    input  logic              s_last,
    input  logic [ADDR_W-1:0] desc_addr,
    output logic [SLOT_W-1:0] slot,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_data,
    output logic              wb_we,
    output logic [SLOT_W-1:0] wb_slot,
    output logic [31:0]       wb_word,
    output logic [IDX_W-1:0]  prod,
    output logic [DROP_W-1:0] drops
);

    localparam int CNT_W = $clog2(BUF_BYTES + 1);

    typedef struct packed {
        logic              in_frame;
        logic              drop;
        logic              ovf;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] base;
        logic              buf_we;
        logic [ADDR_W-1:0] buf_addr;
        logic [7:0]        buf_data;
        logic              wb_we;
        logic [SLOT_W-1:0] wb_slot;
        logic [31:0]       wb_word;
        logic [IDX_W-1:0]  prod;
        logic [SLOT_W-1:0] slot;
        logic [DROP_W-1:0] drops;
    } wr_state_t;

    wr_state_t st_q, st_d;
    logic              drop_v;
    logic              ovf_v;
    logic [CNT_W-1:0]  cnt_v;
    logic [ADDR_W-1:0] base_v;

    always_comb begin
        st_d        = st_q;
        st_d.buf_we = 1'b0;
        st_d.wb_we  = 1'b0;
        drop_v      = st_q.drop;
        ovf_v       = st_q.ovf;
        cnt_v       = st_q.cnt;
        base_v      = st_q.base;
        if (s_valid) begin
            if (!st_q.in_frame) begin
                drop_v = full;
                ovf_v  = 1'b0;
                base_v = desc_addr;
                cnt_v  = align_en ? CNT_W'(PAD_BYTES) : '0;
                if (full) begin
                    st_d.drops = st_q.drops + DROP_W'(1);
                end
            end
            if (!drop_v) begin
                if (cnt_v < CNT_W'(BUF_BYTES)) begin
                    st_d.buf_we   = 1'b1;
                    st_d.buf_addr = base_v + ADDR_W'(cnt_v);
                    st_d.buf_data = s_data;
                    cnt_v         = cnt_v + CNT_W'(1);
                end else begin
                    ovf_v = 1'b1;
                end
            end
            st_d.in_frame = !s_last;
            st_d.drop     = drop_v;
            st_d.ovf      = ovf_v;
            st_d.cnt      = cnt_v;
            st_d.base     = base_v;
            if (s_last && !drop_v) begin
                st_d.wb_we   = 1'b1;
                st_d.wb_slot = st_q.slot;
                st_d.wb_word = make_status(LEN_BITS'(cnt_v), ovf_v);
                st_d.prod    = st_q.prod + IDX_W'(1);
                st_d.slot    = st_q.slot + SLOT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot     = st_q.slot;
    assign buf_we   = st_q.buf_we;
    assign buf_addr = st_q.buf_addr;
    assign buf_data = st_q.buf_data;
    assign wb_we    = st_q.wb_we;
    assign wb_slot  = st_q.wb_slot;
    assign wb_word  = st_q.wb_word;
    assign prod     = st_q.prod;
    assign drops    = st_q.drops;

    // R6: byte writes stay inside the buffer window
    assert_in_buffer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.buf_we |-> ((st_q.buf_addr - st_q.base) < ADDR_W'(BUF_BYTES)));

    // R6: reported length never exceeds the buffer size
    assert_len_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wb_we |-> (st_q.wb_word[LEN_LSB +: LEN_BITS] <= LEN_BITS'(BUF_BYTES)));

    // R5: producer index steps by one, only with a write-back
    assert_prod_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.prod != $past(st_q.prod)) |-> (st_q.wb_we && st_q.prod == $past(st_q.prod) + IDX_W'(1)));

    // R7: slot pointer follows the producer index modulo the ring size
    assert_slot_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slot == st_q.prod[SLOT_W-1:0]);

    // R8: a frame starting on a full ring writes nothing
    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !st_q.in_frame && full) |=> (!st_q.buf_we && !st_q.wb_we));

endmodule

// File: rtl/rx_ring_dma_writer.sv
module rx_ring_dma_writer #(
    parameter int SLOTS     = 256,
    parameter int BUF_BYTES = 2048,
    parameter int IDX_W     = 16,
    parameter int ADDR_W    = 32,
    parameter int DROP_W    = 16,
    parameter int PAD_BYTES = 2,
    parameter int XOFF_AT   = 5,
    parameter int XON_AT    = SLOTS / 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     align_en,
    input  logic [IDX_W-1:0]         cons_idx,
    input  logic [7:0]               s_axis_tdata,
    input  logic                     s_axis_tvalid,
    output logic                     s_axis_tready,
    input  logic                     s_axis_tlast,
    output logic [$clog2(SLOTS)-1:0] desc_slot,
    input  logic [ADDR_W-1:0]        desc_buf_addr,
    output logic                     buf_we,
    output logic [ADDR_W-1:0]        buf_addr,
    output logic [7:0]               buf_wdata,
    output logic                     wb_we,
    output logic [$clog2(SLOTS)-1:0] wb_slot,
    output logic [31:0]              wb_word,
    output logic [IDX_W-1:0]         prod_idx,
    output logic                     xoff,
    output logic [DROP_W-1:0]        drop_count
);

    localparam int SLOT_W = $clog2(SLOTS);

    logic ring_full;

    assign s_axis_tready = 1'b1;

    rxring_occupancy #(
        .SLOTS  (SLOTS),
        .IDX_W  (IDX_W),
        .XOFF_AT(XOFF_AT),
        .XON_AT (XON_AT)
    ) u_occ (
        .clk  (clk),
        .rst_n(rst_n),
        .prod (prod_idx),
        .cons (cons_idx),
        .full (ring_full),
        .xoff (xoff)
    );

    rxring_frame_writer #(
        .BUF_BYTES(BUF_BYTES),
        .SLOT_W   (SLOT_W),
        .IDX_W    (IDX_W),
        .ADDR_W   (ADDR_W),
        .DROP_W   (DROP_W),
        .PAD_BYTES(PAD_BYTES)
    ) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .align_en (align_en),
        .full     (ring_full),
        .s_data   (s_axis_tdata),
        .s_valid  (s_axis_tvalid),
        .s_last   (s_axis_tlast),
        .desc_addr(desc_buf_addr),
        .slot     (desc_slot),
        .buf_we   (buf_we),
        .buf_addr (buf_addr),
        .buf_data (buf_wdata),
        .wb_we    (wb_we),
        .wb_slot  (wb_slot),
        .wb_word  (wb_word),
        .prod     (prod_idx),
        .drops    (drop_count)
    );

endmodule

// File: tb/rx_ring_dma_writer_test.sv
module rx_ring_dma_writer_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        align_en = 1'b0;
    logic [15:0] cons_idx = '0;
    logic [7:0]  tdata = '0;
    logic        tvalid = 1'b0;
    logic        tlast = 1'b0;
    logic        tready;
    logic [7:0]  desc_slot;
    logic [31:0] desc_buf_addr;
    logic        buf_we;
    logic [31:0] buf_addr;
    logic [7:0]  buf_wdata;
    logic        wb_we;
    logic [7:0]  wb_slot;
    logic [31:0] wb_word;
    logic [15:0] prod_idx;
    logic        xoff;
    logic [15:0] drop_count;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] addr_of(input int s);
        return 32'h0010_0040 + 32'(s) * 32'd4096;
    endfunction

    assign desc_buf_addr = addr_of(int'(desc_slot));

    rx_ring_dma_writer uut (
        .clk(clk), .rst_n(rst_n), .align_en(align_en), .cons_idx(cons_idx),
        .s_axis_tdata(tdata), .s_axis_tvalid(tvalid), .s_axis_tready(tready),
        .s_axis_tlast(tlast), .desc_slot(desc_slot), .desc_buf_addr(desc_buf_addr),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .wb_we(wb_we), .wb_slot(wb_slot), .wb_word(wb_word),
        .prod_idx(prod_idx), .xoff(xoff), .drop_count(drop_count)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit          m_in, m_drop, m_ovf, m_xoff;
    int          m_cnt, m_prod, m_slot, m_drops;
    logic [31:0] m_base;
    bit          e_bwe, e_wwe;
    logic [31:0] e_baddr, e_wword;
    logic [7:0]  e_bdata;
    int          e_wslot;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_in = 0; m_drop = 0; m_ovf = 0; m_xoff = 0; m_cnt = 0;
            m_prod = 0; m_slot = 0; m_drops = 0; m_base = '0;
            e_bwe = 0; e_wwe = 0;
        end else begin
            int  occ, free_n;
            bit  full, nx;
            occ    = (m_prod - int'(cons_idx)) & 16'hffff;
            full   = occ >= 256;
            free_n = full ? 0 : 256 - occ;
            nx     = m_xoff ? !(free_n >= 16) : (free_n <= 5);
            e_bwe  = 0;
            e_wwe  = 0;
            if (tvalid) begin
                if (!m_in) begin
                    m_drop = full;
                    m_base = addr_of(m_slot);
                    m_cnt  = align_en ? 2 : 0;
                    m_ovf  = 0;
                    if (full) m_drops = (m_drops + 1) & 16'hffff;
                end
                if (!m_drop) begin
                    if (m_cnt < 2048) begin
                        e_bwe = 1; e_baddr = m_base + 32'(m_cnt); e_bdata = tdata;
                        m_cnt++;
                    end else m_ovf = 1;
                end
                m_in = !tlast;
                if (tlast && !m_drop) begin
                    e_wwe = 1; e_wslot = m_slot;
                    e_wword = (32'(m_cnt) << 16) | 32'h6000 | 32'(m_ovf);
                    m_prod = (m_prod + 1) & 16'hffff;
                    m_slot = (m_slot + 1) % 256;
                end
            end
            m_xoff = nx;
        end
    end

    logic [31:0] last_word;
    int          last_slot, wr_count;
    logic [31:0] first_addr;
    bit          first_seen;

    always @(negedge clk) begin
        if (rst_n) begin
            check(tready == 1'b1, "R2 tready", tready, 1);
            check(buf_we == e_bwe, "R3 buf_we", buf_we, e_bwe);
            if (e_bwe && buf_we) begin
                check(buf_addr == e_baddr, "R3 buf_addr", buf_addr, e_baddr);
                check(buf_wdata == e_bdata, "R3 buf_wdata", buf_wdata, e_bdata);
            end
            check(wb_we == e_wwe, "R5 wb_we", wb_we, e_wwe);
            if (e_wwe && wb_we) begin
                check(wb_word == e_wword, "R5 wb_word", wb_word, e_wword);
                check(int'(wb_slot) == e_wslot, "R7 wb_slot", wb_slot, e_wslot);
            end
            check(int'(prod_idx) == m_prod, "R5 prod_idx", prod_idx, m_prod);
            check(xoff == m_xoff, "R9 xoff", xoff, m_xoff);
            check(int'(drop_count) == m_drops, "R8 drop_count", drop_count, m_drops);
            if (wb_we) begin last_word = wb_word; last_slot = int'(wb_slot); end
            if (buf_we) begin
                wr_count++;
                if (!first_seen) begin first_addr = buf_addr; first_seen = 1; end
            end
        end
    end

    task automatic send_frame(input int n, input bit al, input int seed);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            tvalid = 1; align_en = al; tdata = 8'((i * 7 + seed) & 8'hff);
            tlast = (i == n - 1);
        end
        @(posedge clk); #1;
        tvalid = 0; tlast = 0;
        @(posedge clk); #1;
    endtask

    task automatic clear_obs();
        wr_count = 0; first_seen = 0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait_cycles(3);
        // R1 reset state
        check(prod_idx == 0 && xoff == 0 && drop_count == 0 && buf_we == 0 && wb_we == 0
              && desc_slot == 0, "R1 reset", {prod_idx, drop_count}, 0);
        #2 rst_n = 1;
        wait_cycles(2);

        // R3 plain frame
        clear_obs();
        send_frame(5, 0, 3);
        check(first_addr == addr_of(0), "R3 start addr", first_addr, addr_of(0));
        check(last_word[27:16] == 5 && !last_word[0], "R5 length 5", last_word, 32'h0005_6000);

        // R4 aligned frame
        clear_obs();
        send_frame(7, 1, 9);
        check(first_addr == addr_of(1) + 2, "R4 pad addr", first_addr, addr_of(1) + 2);
        check(last_word[27:16] == 9, "R4 length with pad", last_word[27:16], 9);

        // single-byte frame
        send_frame(1, 0, 1);
        check(last_word == 32'h0001_6000, "R5 single byte", last_word, 32'h0001_6000);

        // R6 truncation
        clear_obs();
        send_frame(2100, 1, 5);
        check(wr_count == 2046, "R6 bytes stored", wr_count, 2046);
        check(last_word[27:16] == 12'h800 && last_word[0], "R6 len/ovf", last_word, 32'h0800_6001);
        check(prod_idx == 4, "R5 prod after 4", prod_idx, 4);

        // fill ring to 256
        for (int f = 0; f < 252; f++) send_frame(1, 0, f);
        wait_cycles(2);
        check(prod_idx == 256, "R7 prod 256", prod_idx, 256);
        check(xoff == 1, "R9 xoff on full", xoff, 1);

        // R8 drops on full ring
        clear_obs();
        send_frame(4, 0, 2); send_frame(1, 1, 2); send_frame(3, 0, 2);
        check(drop_count == 3, "R8 drop count", drop_count, 3);
        check(wr_count == 0, "R8 no writes", wr_count, 0);
        check(prod_idx == 256, "R8 prod held", prod_idx, 256);

        // R10 hysteresis hold and release
        cons_idx = 10; wait_cycles(3);
        check(xoff == 1, "R10 xoff held at 10 free", xoff, 1);
        cons_idx = 240; wait_cycles(3);
        check(xoff == 0, "R10 xoff released", xoff, 0);

        // R7 slot wrap
        send_frame(2, 0, 4);
        check(last_slot == 0, "R7 slot wrap", last_slot, 0);
        check(prod_idx == 257, "R7 prod 257", prod_idx, 257);

        // R9 boundary: 6 free keeps low, 5 free raises
        cons_idx = 7; wait_cycles(3);
        check(xoff == 0, "R9 six free", xoff, 0);
        cons_idx = 6; wait_cycles(3);
        check(xoff == 1, "R9 five free", xoff, 1);
        // R10 boundary: 15 free holds, 16 free releases
        cons_idx = 16; wait_cycles(3);
        check(xoff == 1, "R10 fifteen free", xoff, 1);
        cons_idx = 17; wait_cycles(3);
        check(xoff == 0, "R10 sixteen free", xoff, 0);

        // back-to-back frames after consuming
        send_frame(3, 1, 11); send_frame(4, 0, 12);
        check(last_word[27:16] == 4 && last_slot == 2, "R5 back to back", last_word, 32'h0004_6000);

        wait_cycles(3);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule